// File: doc/BRIEF.md
# Service-Category Transmit Credit Gate

This block decides, one request per cycle, whether a virtual circuit may take another transmit particle from a shared buffer pool. Each circuit has a service category and a credit. The credit is the most particles the circuit may hold while its cap is enforced. For a sustained-rate circuit the credit is derived from its sustained cell rate. For an available-rate or an unspecified-rate circuit it is a fixed default. Software may replace the derived value with a credit of its own. The pool holds 6144 particles of 576 bytes. Of these, 144 form a reserved region for system cells (maintenance traffic), and data circuits can never use that region.

Enforcement depends on the category. Sustained-rate and available-rate circuits are always held to their credit. Unspecified-rate circuits may exceed their credit while the pool is lightly loaded. They are held to it only while total data usage is above a threshold: 75 percent of the data capacity, or a programmed value. Every comparison uses the current counters with any release in the same cycle already subtracted, so a release and a request in one cycle do not lose an opportunity. The grant is combinational. The counters update on the next clock edge.

Top module: `tcg_credit_gate`

## Requirements
- R1: A system-cell request (req_sys=1) is granted exactly when the system count, less a system release in the same cycle, is below 144. It is granted whatever the data usage, and sys_total never exceeds 144.
- R2: A data request is never granted while data_total, less a valid data release in the same cycle, is at 6000 or more (6144 minus 144 reserved). data_total never exceeds 6000.
- R3: When a circuit is configured with category code 0 (sustained rate) and no override, its credit is floor(48 × cfg_scr / (576 × 5)). A result of 0 becomes 1. The credit is readable on qry_credit.
- R4: Category code 1 (available rate) gets credit 128. Codes 2 and 3 (unspecified rate; 3 behaves as 2) get credit 40.
- R5: A configuration write with cfg_ovr=1 stores cfg_credit as the circuit's credit, in place of the category default.
- R6: For categories 0 and 1, a data request is granted only if the circuit's usage, less a same-cycle release on that circuit, is below its credit.
- R7: For categories 2 and 3, the credit is applied only while ubr_enforce is high. ubr_enforce is high when data_total, less a same-cycle data release, exceeds the threshold. The threshold is the programmed value when that value is non-zero, and 4500 (75 percent of 6000) when it is zero.
- R8: At each clock edge, a circuit's usage rises by one for a granted data request and falls by one for a data release. A release on a circuit whose usage is zero, or a system release while sys_total is zero, is ignored.
- R9: After reset every circuit has category 2, credit 40 and usage 0, both totals are 0 and the threshold register is 0.
- R10: A system request or release leaves data_total and every circuit's usage unchanged. A configuration write leaves the usage of every circuit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Circuit configuration write |
| cfg_vc | input | 3 | Circuit being configured |
| cfg_cat | input | 2 | Category: 0 sustained, 1 available, 2/3 unspecified |
| cfg_scr | input | 24 | Sustained cell rate, overhead included |
| cfg_ovr | input | 1 | Use cfg_credit instead of the computed default |
| cfg_credit | input | 20 | Override credit in particles |
| thr_we | input | 1 | Threshold register write |
| thr_val | input | 13 | Threshold in particles; 0 selects 75 percent |
| req_valid | input | 1 | Particle request |
| req_sys | input | 1 | Request is for the reserved region |
| req_vc | input | 3 | Requesting circuit |
| grant | output | 1 | Request admitted this cycle |
| rel_valid | input | 1 | Particle release |
| rel_sys | input | 1 | Release is from the reserved region |
| rel_vc | input | 3 | Releasing circuit |
| qry_vc | input | 3 | Circuit to observe |
| qry_credit | output | 20 | Credit of qry_vc |
| qry_used | output | 13 | Particles held by qry_vc |
| data_total | output | 13 | Particles held by all data circuits |
| sys_total | output | 8 | Particles held in the reserved region |
| ubr_enforce | output | 1 | Unspecified-rate caps currently applied |

## Verification
The bench drives a circuit with a very low rate to check the clamp to one particle. A design without the clamp would leave that circuit with credit 0, and it could never transmit. The bench fills an unspecified-rate circuit past 40 particles below the threshold, then crosses the threshold. A design that always capped these circuits, or never capped them, denies or grants the wrong request. The bench fills the data pool to 6000 and the reserved region to 144, and checks that each limit is independent of the other. A release arrives in the same cycle as a request on a full circuit. A design that compared against stale counters would deny that request. Releases on empty counters must not wrap a count.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  typedef enum logic [1:0] {
    CAT_SUST  = 2'd0,
    CAT_AVAIL = 2'd1,
    CAT_UNSP  = 2'd2,
    CAT_UNSP2 = 2'd3
  } cat_e;

  function automatic logic is_unsp(input logic [1:0] c);
    return (c == CAT_UNSP) || (c == CAT_UNSP2);
  endfunction
endpackage

// File: rtl/tcg_credit_calc.sv
module tcg_credit_calc #(
  parameter int SCRW       = 24,
  parameter int CRW        = 20,
  parameter int PART_BYTES = 576,
  parameter int AVAIL_CRED = 128,
  parameter int UNSP_CRED  = 40
) (
  input  logic [1:0]      cat_i,
  input  logic [SCRW-1:0] scr_i,
  input  logic            ovr_i,
  input  logic [CRW-1:0]  ovr_credit_i,
  output logic [CRW-1:0]  credit_o
);
  import tcg_pkg::*;

  localparam int PRW     = SCRW + 8;
  localparam int DIVISOR = PART_BYTES * 5;
  localparam logic [PRW-1:0] CR_MAX = PRW'((64'd1 << CRW) - 64'd1);

  logic [PRW-1:0] prod;
  logic [PRW-1:0] quo;
  logic [CRW-1:0] sust_cred;

  always_comb begin
    prod = PRW'(scr_i) * PRW'(48);
    quo  = prod / PRW'(DIVISOR);
    if (quo == '0)
      sust_cred = CRW'(1);
    else if (quo > CR_MAX)
      sust_cred = CR_MAX[CRW-1:0];
    else
      sust_cred = quo[CRW-1:0];
  end

  always_comb begin
    if (ovr_i)
      credit_o = ovr_credit_i;
    else if (cat_i == CAT_SUST)
      credit_o = sust_cred;
    else if (cat_i == CAT_AVAIL)
      credit_o = CRW'(AVAIL_CRED);
    else
      credit_o = CRW'(UNSP_CRED);
  end
endmodule

// File: rtl/tcg_pool.sv
module tcg_pool #(
  parameter int CNTW  = 13,
  parameter int LIMIT = 6000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc_i,
  input  logic            dec_i,
  output logic [CNTW-1:0] count_o
);
  logic [CNTW-1:0] count_q;
  logic [CNTW-1:0] count_d;

  always_comb begin
    count_d = count_q;
    if (inc_i && !dec_i)
      count_d = count_q + CNTW'(1);
    else if (dec_i && !inc_i)
      count_d = count_q - CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (inc_i != dec_i)
      count_q <= count_d;
  end

  assign count_o = count_q;

  AST_POOL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNTW'(LIMIT)); // R1
  AST_POOL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i) |-> (count_q != '0)); // R8
endmodule

// File: rtl/tcg_vc_table.sv
module tcg_vc_table #(
  parameter int NUM_VC    = 8,
  parameter int VCW       = 3,
  parameter int CNTW      = 13,
  parameter int CRW       = 20,
  parameter int RST_CRED  = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [VCW-1:0]  cfg_vc,
  input  logic [1:0]      cfg_cat,
  input  logic [CRW-1:0]  cfg_credit,
  input  logic            inc_en,
  input  logic [VCW-1:0]  inc_vc,
  input  logic            dec_en,
  input  logic [VCW-1:0]  dec_vc,
  input  logic [VCW-1:0]  rd_vc,
  output logic [1:0]      rd_cat,
  output logic [CRW-1:0]  rd_credit,
  output logic [CNTW-1:0] rd_used,
  input  logic [VCW-1:0]  rl_vc,
  output logic [CNTW-1:0] rl_used,
  input  logic [VCW-1:0]  qry_vc,
  output logic [CRW-1:0]  qry_credit,
  output logic [CNTW-1:0] qry_used
);
  import tcg_pkg::*;

  logic [NUM_VC-1:0][1:0]      cat_q,  cat_d;
  logic [NUM_VC-1:0][CRW-1:0]  cred_q, cred_d;
  logic [NUM_VC-1:0][CNTW-1:0] used_q, used_d;
  logic [NUM_VC-1:0]           cfg_hit, inc_hit, dec_hit;

  always_comb begin
    for (int i = 0; i < NUM_VC; i++) begin
      cfg_hit[i] = cfg_we && (cfg_vc == VCW'(i));
      inc_hit[i] = inc_en && (inc_vc == VCW'(i));
      dec_hit[i] = dec_en && (dec_vc == VCW'(i));
      cat_d[i]   = cfg_hit[i] ? cfg_cat    : cat_q[i];
      cred_d[i]  = cfg_hit[i] ? cfg_credit : cred_q[i];
      used_d[i]  = used_q[i];
      if (inc_hit[i] && !dec_hit[i])
        used_d[i] = used_q[i] + CNTW'(1);
      else if (dec_hit[i] && !inc_hit[i])
        used_d[i] = used_q[i] - CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VC; i++) begin
        cat_q[i]  <= CAT_UNSP;
        cred_q[i] <= CRW'(RST_CRED);
        used_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_VC; i++) begin
        if (cfg_hit[i]) begin
          cat_q[i]  <= cat_d[i];
          cred_q[i] <= cred_d[i];
        end
        if (inc_hit[i] != dec_hit[i])
          used_q[i] <= used_d[i];
      end
    end
  end

  assign rd_cat     = cat_q[rd_vc];
  assign rd_credit  = cred_q[rd_vc];
  assign rd_used    = used_q[rd_vc];
  assign rl_used    = used_q[rl_vc];
  assign qry_credit = cred_q[qry_vc];
  assign qry_used   = used_q[qry_vc];

  AST_USED_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !(inc_en && inc_vc == dec_vc)) |-> (used_q[dec_vc] != '0)); // R8
endmodule

// File: rtl/tcg_credit_gate.sv
module tcg_credit_gate #(
  parameter int NUM_VC     = 8,
  parameter int VCW        = 3,
  parameter int SCRW       = 24,
  parameter int CRW        = 20,
  parameter int TOTAL_PART = 6144,
  parameter int RSVD_PART  = 144,
  parameter int PART_BYTES = 576,
  parameter int AVAIL_CRED = 128,
  parameter int UNSP_CRED  = 40,
  parameter int THR_PCT    = 75,
  parameter int CNTW       = 13,
  parameter int SYSW       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [VCW-1:0]  cfg_vc,
  input  logic [1:0]      cfg_cat,
  input  logic [SCRW-1:0] cfg_scr,
  input  logic            cfg_ovr,
  input  logic [CRW-1:0]  cfg_credit,
  input  logic            thr_we,
  input  logic [CNTW-1:0] thr_val,
  input  logic            req_valid,
  input  logic            req_sys,
  input  logic [VCW-1:0]  req_vc,
  output logic            grant,
  input  logic            rel_valid,
  input  logic            rel_sys,
  input  logic [VCW-1:0]  rel_vc,
  input  logic [VCW-1:0]  qry_vc,
  output logic [CRW-1:0]  qry_credit,
  output logic [CNTW-1:0] qry_used,
  output logic [CNTW-1:0] data_total,
  output logic [SYSW-1:0] sys_total,
  output logic            ubr_enforce
);
  import tcg_pkg::*;

  localparam int DATA_CAP = TOTAL_PART - RSVD_PART;
  localparam int DEF_THR  = (DATA_CAP * THR_PCT) / 100;

  logic [CRW-1:0]  new_credit;
  logic [1:0]      rd_cat;
  logic [CRW-1:0]  rd_credit;
  logic [CNTW-1:0] rd_used;
  logic [CNTW-1:0] rl_used;
  logic [CNTW-1:0] thr_q, thr_d, thr_eff;
  logic            rel_data_ok, rel_sys_ok, rel_same_vc;
  logic [CNTW-1:0] tot_eff, vc_eff;
  logic [SYSW-1:0] sys_eff;
  logic            pool_ok, cred_ok, cap_on;
  logic            grant_data, grant_sys;

  tcg_credit_calc #(
    .SCRW(SCRW), .CRW(CRW), .PART_BYTES(PART_BYTES),
    .AVAIL_CRED(AVAIL_CRED), .UNSP_CRED(UNSP_CRED)
  ) calc_i (
    .cat_i(cfg_cat), .scr_i(cfg_scr), .ovr_i(cfg_ovr),
    .ovr_credit_i(cfg_credit), .credit_o(new_credit)
  );

  tcg_vc_table #(
    .NUM_VC(NUM_VC), .VCW(VCW), .CNTW(CNTW), .CRW(CRW), .RST_CRED(UNSP_CRED)
  ) table_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_vc(cfg_vc), .cfg_cat(cfg_cat), .cfg_credit(new_credit),
    .inc_en(grant_data), .inc_vc(req_vc),
    .dec_en(rel_data_ok), .dec_vc(rel_vc),
    .rd_vc(req_vc), .rd_cat(rd_cat), .rd_credit(rd_credit), .rd_used(rd_used),
    .rl_vc(rel_vc), .rl_used(rl_used),
    .qry_vc(qry_vc), .qry_credit(qry_credit), .qry_used(qry_used)
  );

  tcg_pool #(.CNTW(CNTW), .LIMIT(DATA_CAP)) data_pool_i (
    .clk(clk), .rst_n(rst_n), .inc_i(grant_data), .dec_i(rel_data_ok),
    .count_o(data_total)
  );

  tcg_pool #(.CNTW(SYSW), .LIMIT(RSVD_PART)) sys_pool_i (
    .clk(clk), .rst_n(rst_n), .inc_i(grant_sys), .dec_i(rel_sys_ok),
    .count_o(sys_total)
  );

  // threshold register
  always_comb begin
    thr_d = thr_we ? thr_val : thr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      thr_q <= '0;
    else if (thr_we)
      thr_q <= thr_d;
  end

  // release-aware view of the counters
  always_comb begin
    rel_data_ok = rel_valid && !rel_sys && (rl_used != '0);
    rel_sys_ok  = rel_valid &&  rel_sys && (sys_total != '0);
    rel_same_vc = rel_data_ok && (rel_vc == req_vc);
    tot_eff     = data_total - CNTW'(rel_data_ok);
    sys_eff     = sys_total - SYSW'(rel_sys_ok);
    vc_eff      = rd_used - CNTW'(rel_same_vc);
    thr_eff     = (thr_q == '0) ? CNTW'(DEF_THR) : thr_q;
    ubr_enforce = tot_eff > thr_eff;
  end

  // admission decision
  always_comb begin
    pool_ok    = tot_eff < CNTW'(DATA_CAP);
    cred_ok    = {{(CRW > CNTW ? CRW - CNTW : 0){1'b0}}, vc_eff} < rd_credit;
    cap_on     = !is_unsp(rd_cat) || ubr_enforce;
    grant_data = req_valid && !req_sys && pool_ok && (!cap_on || cred_ok);
    grant_sys  = req_valid &&  req_sys && (sys_eff < SYSW'(RSVD_PART));
    grant      = grant_data || grant_sys;
  end

  AST_SUST_MIN_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_cat == CAT_SUST && !cfg_ovr) |-> (new_credit != '0)); // R3
  AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_sys && !is_unsp(rd_cat) && !rel_same_vc &&
     {{(CRW > CNTW ? CRW - CNTW : 0){1'b0}}, rd_used} >= rd_credit) |-> !grant); // R6
  AST_SYS_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sys && !(rel_valid && !rel_sys)) |=> $stable(data_total)); // R10
  AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !req_sys && !(rel_valid && !rel_sys)) |=> (data_total == $past(data_total) + CNTW'(1))); // R2
  AST_FULL_POOL_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_sys && !rel_valid && data_total >= CNTW'(DATA_CAP)) |-> !grant); // R2
endmodule

// File: tb/tcg_credit_gate_tb_top.sv
`timescale 1ns/1ps
module tcg_credit_gate_tb_top;
  localparam int NV = 8;

  logic        clk, rst_n;
  logic        cfg_we, cfg_ovr, thr_we;
  logic [2:0]  cfg_vc, req_vc, rel_vc, qry_vc;
  logic [1:0]  cfg_cat;
  logic [23:0] cfg_scr;
  logic [19:0] cfg_credit;
  logic [12:0] thr_val;
  logic        req_valid, req_sys, rel_valid, rel_sys;
  logic        grant, ubr_enforce;
  logic [19:0] qry_credit;
  logic [12:0] qry_used, data_total;
  logic [7:0]  sys_total;

  tcg_credit_gate dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_vc(cfg_vc), .cfg_cat(cfg_cat), .cfg_scr(cfg_scr),
    .cfg_ovr(cfg_ovr), .cfg_credit(cfg_credit),
    .thr_we(thr_we), .thr_val(thr_val),
    .req_valid(req_valid), .req_sys(req_sys), .req_vc(req_vc), .grant(grant),
    .rel_valid(rel_valid), .rel_sys(rel_sys), .rel_vc(rel_vc),
    .qry_vc(qry_vc), .qry_credit(qry_credit), .qry_used(qry_used),
    .data_total(data_total), .sys_total(sys_total), .ubr_enforce(ubr_enforce)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  int m_cat[NV];
  int m_cred[NV];
  int m_used[NV];
  int m_tot, m_sys, m_thr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int f_credit(input int cat, input int scr, input bit ovr, input int cr);
    longint q;
    if (ovr) return cr;
    if (cat == 0) begin
      q = (longint'(48) * scr) / (576 * 5);
      if (q == 0) q = 1;
      return int'(q);
    end
    if (cat == 1) return 128;
    return 40;
  endfunction

  function automatic int f_thr();
    return (m_thr == 0) ? 4500 : m_thr;
  endfunction

  function automatic bit f_grant(input bit rv, input bit rs, input int rvc,
                                 input bit lv, input bit ls, input int lvc);
    bit rd = lv && !ls && (m_used[lvc] != 0);
    bit rsy = lv && ls && (m_sys != 0);
    int tot = m_tot - int'(rd);
    int sy = m_sys - int'(rsy);
    int ve = m_used[rvc] - int'(rd && lvc == rvc);
    if (!rv) return 0;
    if (rs) return sy < 144;
    if (tot >= 6000) return 0;
    if (m_cat[rvc] >= 2) return (tot <= f_thr()) || (ve < m_cred[rvc]);
    return ve < m_cred[rvc];
  endfunction

  task automatic step(input bit rv, input bit rs, input int rvc,
                      input bit lv, input bit ls, input int lvc, input string tag);
    bit eg, rd, rsy;
    int tot;
    @(negedge clk);
    req_valid = rv; req_sys = rs; req_vc = 3'(rvc);
    rel_valid = lv; rel_sys = ls; rel_vc = 3'(lvc);
    qry_vc = 3'(rvc);
    #1;
    eg  = f_grant(rv, rs, rvc, lv, ls, lvc);
    rd  = lv && !ls && (m_used[lvc] != 0);
    rsy = lv && ls && (m_sys != 0);
    tot = m_tot - int'(rd);
    chk(grant == eg, tag, int'(grant), int'(eg));
    chk(ubr_enforce == (tot > f_thr()), "R7 ubr_enforce", int'(ubr_enforce), int'(tot > f_thr()));
    chk(int'(qry_used) == m_used[rvc], "R8 qry_used", int'(qry_used), m_used[rvc]);
    chk(int'(data_total) == m_tot, "R2 data_total", int'(data_total), m_tot);
    chk(int'(sys_total) == m_sys, "R1 sys_total", int'(sys_total), m_sys);
    @(posedge clk);
    if (eg && !rs) begin m_used[rvc]++; m_tot++; end
    if (eg && rs) m_sys++;
    if (rd) begin m_used[lvc]--; m_tot--; end
    if (rsy) m_sys--;
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_sys = 0; rel_valid = 0; rel_sys = 0;
    cfg_we = 0; thr_we = 0;
  endtask

  task automatic cfg(input int vc, input int cat, input int scr, input bit ovr, input int cr);
    @(negedge clk);
    idle_inputs();
    cfg_we = 1; cfg_vc = 3'(vc); cfg_cat = 2'(cat); cfg_scr = 24'(scr);
    cfg_ovr = ovr; cfg_credit = 20'(cr);
    @(posedge clk);
    m_cat[vc] = cat;
    m_cred[vc] = f_credit(cat, scr, ovr, cr);
    @(negedge clk);
    cfg_we = 0;
    qry_vc = 3'(vc);
    #1;
    chk(int'(qry_credit) == m_cred[vc], "R3/R4/R5 qry_credit", int'(qry_credit), m_cred[vc]);
    chk(int'(qry_used) == m_used[vc], "R10 usage after config", int'(qry_used), m_used[vc]);
  endtask

  task automatic set_thr(input int v);
    @(negedge clk);
    idle_inputs();
    thr_we = 1; thr_val = 13'(v);
    @(posedge clk);
    m_thr = v;
    @(negedge clk);
    thr_we = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    idle_inputs();
    cfg_vc = 0; cfg_cat = 0; cfg_scr = 0; cfg_ovr = 0; cfg_credit = 0;
    thr_val = 0; req_vc = 0; rel_vc = 0; qry_vc = 0;
    for (int i = 0; i < NV; i++) begin m_cat[i] = 2; m_cred[i] = 40; m_used[i] = 0; end
    m_tot = 0; m_sys = 0; m_thr = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R9 reset state
    for (int i = 0; i < NV; i++) begin
      qry_vc = 3'(i);
      #1;
      chk(qry_credit == 20'd40, "R9 reset credit", int'(qry_credit), 40);
      chk(qry_used == 13'd0, "R9 reset usage", int'(qry_used), 0);
    end
    chk(data_total == 0 && sys_total == 0, "R9 reset totals", int'(data_total), 0);
    chk(ubr_enforce == 0, "R9 reset threshold", int'(ubr_enforce), 0);

    // R3 R4 R5 credits
    cfg(0, 0, 6000, 0, 0);      // 100
    cfg(5, 0, 30, 0, 0);        // clamp to 1
    cfg(6, 0, 12345678, 0, 0);  // large rate
    cfg(1, 1, 0, 0, 0);         // 128
    cfg(7, 3, 0, 0, 0);         // 40
    cfg(1, 1, 0, 1, 5);         // override 5

    // R3 clamped circuit admits exactly one
    step(1, 0, 5, 0, 0, 0, "R3 clamp first");
    step(1, 0, 5, 0, 0, 0, "R3 clamp second denied");

    // R6 capped circuit
    for (int k = 0; k < 7; k++) step(1, 0, 1, 0, 0, 0, "R6 capped circuit");
    step(1, 0, 1, 1, 0, 1, "R8 release same cycle at cap");
    step(0, 0, 3, 1, 0, 3, "R8 release on empty circuit");

    // R7 unspecified below threshold exceeds 40
    for (int k = 0; k < 60; k++) step(1, 0, 2, 0, 0, 0, "R7 below threshold");
    set_thr(50);
    for (int k = 0; k < 4; k++) step(1, 0, 2, 0, 0, 0, "R7 above programmed threshold");
    step(1, 0, 7, 0, 0, 0, "R7 code 3 under cap above threshold");
    set_thr(0);

    // R1 reserved region
    for (int k = 0; k < 150; k++) step(1, 1, 0, 0, 0, 0, "R1 system request");
    step(0, 0, 0, 1, 1, 0, "R1 system release");
    step(1, 1, 0, 1, 1, 0, "R1 system release plus request");

    // R2 fill pool
    cfg(3, 1, 0, 1, 4000);
    cfg(4, 1, 0, 1, 4000);
    for (int k = 0; k < 4000; k++) step(1, 0, 3, 0, 0, 0, "R2 fill vc3");
    for (int k = 0; k < 2000; k++) step(1, 0, 4, 0, 0, 0, "R2 fill vc4");
    chk(m_tot == 6000, "R2 bench model full", m_tot, 6000);
    step(1, 0, 6, 0, 0, 0, "R2 full pool denies");
    step(1, 0, 4, 1, 0, 3, "R2 full pool with release");
    step(1, 1, 0, 0, 0, 0, "R1 system independent of data");
    step(1, 1, 0, 1, 1, 0, "R1 system when reserved full");

    // drain
    for (int v = 0; v < NV; v++)
      while (m_used[v] > 0) step(0, 0, v, 1, 0, v, "R8 drain");
    while (m_sys > 0) step(0, 0, 0, 1, 1, 0, "R8 drain system");

    // random phase
    for (int k = 0; k < 6000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 2)
        cfg(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 20000)), ($urandom_range(0, 3) == 0),
            int'($urandom_range(0, 300)));
      else if (r < 3)
        set_thr(($urandom_range(0, 1) == 0) ? 0 : int'($urandom_range(1, 400)));
      else
        step($urandom_range(0, 9) < 7, $urandom_range(0, 9) == 0, int'($urandom_range(0, 7)),
             $urandom_range(0, 9) < 4, $urandom_range(0, 9) == 0, int'($urandom_range(0, 7)),
             "R6/R7 random grant");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule